// File: doc/BRIEF.md
# Adaptive Hold Logic Controller

This block sits beside a bypassing array multiplier whose clock period is shorter than its worst-case delay. On every cycle in which the multiplier's input registers accept a new operand pair, the controller counts the zero bits in one operand. A parameter chooses that operand: the multiplicand for a column-bypassing array, or the multiplier for a row-bypassing array. Many zeros mean that most partial-product rows or columns are bypassed, so the multiply settles within one cycle. Too few zeros mean that it needs two cycles. In that case the controller pulls its gate output low for exactly one cycle, which freezes the input registers so that the array gets a second cycle on the same operands.

Two zero-count limits exist. A fresh circuit uses the looser one: more than `ZERO_N` zeros qualifies as one cycle. Timing-error pulses from error-detecting flip-flops at the array output are counted within a window of accepted operations. When more than `ERR_LIMIT` errors fall in one window, the circuit is judged to have slowed with age. A sticky aging flag then switches the decision to the stricter limit, more than `ZERO_N+1` zeros, until reset.

The operands come from the multiplier's own input registers, and `gate_o` is the enable of those registers. This is the only back-pressure in the block. While `gate_o` is low, the operand ports are expected to hold their values, and that cycle is not counted as an operation. There is no valid/ready pair. Every cycle in which `gate_o` is high is an accepted operation.

Top module: `ahl_ctrl`

## Requirements
- R1: After reset, `gate_o` is 1 and `aging_o` is 0.
- R2: With `aging_o` at 0 and `gate_o` at 1, an examined operand holding more than `ZERO_N` zero bits keeps `gate_o` at 1 on the next cycle (one-cycle pattern).
- R3: With `aging_o` at 0 and `gate_o` at 1, an examined operand holding `ZERO_N` or fewer zeros drives `gate_o` to 0 for exactly the next cycle. On the cycle after that, `gate_o` returns to 1 whatever the operand is.
- R4: With `BYPASS` = column (the default), only `mcand_i` is examined and `mplier_i` has no effect on `gate_o`. With `BYPASS` = row, only `mplier_i` is examined.
- R5: Each cycle in which `timing_err_i` is 1 counts one error. When the error counted in a cycle is error number `ERR_LIMIT+1` of the current window, `aging_o` is 1 from the following cycle on.
- R6: Once set, `aging_o` stays at 1 through any further inputs, until reset.
- R7: With `aging_o` at 1, a one-cycle pattern needs more than `ZERO_N+1` zeros. An operand with exactly `ZERO_N+1` zeros causes a one-cycle hold.
- R8: Errors are counted over windows of `WINDOW` cycles in which `gate_o` is 1. The error count clears when a window ends, so `ERR_LIMIT` errors in each of two consecutive windows never set `aging_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcand_i | input | WIDTH | Multiplicand from the input registers |
| mplier_i | input | WIDTH | Multiplier operand from the input registers |
| timing_err_i | input | 1 | One-cycle pulse per detected timing error |
| gate_o | output | 1 | Input-register enable; 0 holds the operands for one cycle |
| aging_o | output | 1 | Sticky flag; 1 selects the stricter zero limit |

## Verification
The bench probes both sides of each zero limit: `ZERO_N` against `ZERO_N+1` zeros before aging, and `ZERO_N+1` against `ZERO_N+2` after aging. A design with an off-by-one compare, or one that never switches limits, holds or skips on the wrong operand. It checks that a hold lasts exactly one cycle even when the same slow operand stays in place. A design that fed back the wrong polarity would hold forever or never release. It drives the unexamined operand to its extreme values to catch a swapped selection. It places `ERR_LIMIT` errors on each side of a window boundary, where a counter that never cleared would set the aging flag too early. Repeated errors after the flag is set and a final reset confirm that the flag is sticky and clears only on reset.

// File: rtl/ahl_pkg.sv
package ahl_pkg;
  typedef enum logic {
    BYP_COLUMN = 1'b0,
    BYP_ROW    = 1'b1
  } bypass_e;
endpackage

// File: rtl/ahl_zero_count.sv
module ahl_zero_count #(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] word_i,
  output logic [CW-1:0]    zeros_o
);
  always_comb begin
    zeros_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      zeros_o = zeros_o + CW'(!word_i[i]);
    end
  end
endmodule

// File: rtl/ahl_judge.sv
module ahl_judge #(
  parameter int WIDTH  = 16,
  parameter int ZERO_N = 7,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic [CW-1:0] zeros_i,
  input  logic          strict_i,
  output logic          one_cycle_o
);
  localparam logic [CW-1:0] LOOSE_LIM  = CW'(ZERO_N);
  localparam logic [CW-1:0] STRICT_LIM = CW'(ZERO_N + 1);

  logic loose_ok;
  logic strict_ok;

  // two judging blocks evaluated in parallel, one selected
  assign loose_ok    = zeros_i > LOOSE_LIM;
  assign strict_ok   = zeros_i > STRICT_LIM;
  assign one_cycle_o = strict_i ? strict_ok : loose_ok;
endmodule

// File: rtl/ahl_aging_mon.sv
module ahl_aging_mon #(
  parameter int WINDOW    = 1024,
  parameter int ERR_LIMIT = 3,
  localparam int WW = (WINDOW > 1) ? $clog2(WINDOW) : 1,
  localparam int EW = (ERR_LIMIT > 0) ? $clog2(ERR_LIMIT + 1) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_fire_i,
  input  logic err_i,
  output logic aged_o
);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW - 1);
  localparam logic [EW-1:0] ERR_MAX  = EW'(ERR_LIMIT);

  logic [WW-1:0] win_cnt;
  logic [EW-1:0] err_cnt;
  logic          win_end;
  logic          over;

  assign win_end = op_fire_i && (win_cnt == WIN_LAST);
  assign over    = err_i && (err_cnt == ERR_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
      err_cnt <= '0;
      aged_o  <= 1'b0;
    end else begin
      if (win_end) begin
        win_cnt <= '0;
        err_cnt <= '0;
      end else begin
        if (op_fire_i) win_cnt <= win_cnt + 1'b1;
        if (err_i && (err_cnt != ERR_MAX)) err_cnt <= err_cnt + 1'b1;
      end
      if (over) aged_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ahl_ctrl.sv
module ahl_ctrl #(
  parameter int              WIDTH     = 16,
  parameter int              ZERO_N    = 7,
  parameter int              WINDOW    = 1024,
  parameter int              ERR_LIMIT = 3,
  parameter ahl_pkg::bypass_e BYPASS   = ahl_pkg::BYP_COLUMN,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  input  logic             timing_err_i,
  output logic             gate_o,
  output logic             aging_o
);
  logic [WIDTH-1:0] exam;
  logic [CW-1:0]    zeros;
  logic             one_cycle;
  logic             hold_d;

  generate
    if (BYPASS == ahl_pkg::BYP_COLUMN) begin : g_col
      assign exam = mcand_i;
    end else begin : g_row
      assign exam = mplier_i;
    end
  endgenerate

  ahl_zero_count #(.WIDTH(WIDTH)) u_zc (
    .word_i  (exam),
    .zeros_o (zeros)
  );

  ahl_judge #(.WIDTH(WIDTH), .ZERO_N(ZERO_N)) u_judge (
    .zeros_i     (zeros),
    .strict_i    (aging_o),
    .one_cycle_o (one_cycle)
  );

  ahl_aging_mon #(.WINDOW(WINDOW), .ERR_LIMIT(ERR_LIMIT)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_fire_i (gate_o),
    .err_i     (timing_err_i),
    .aged_o    (aging_o)
  );

  // a held cycle always releases on the next edge
  assign hold_d = one_cycle | ~gate_o;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_o <= 1'b1;
    else        gate_o <= hold_d;
  end
endmodule

// File: rtl/ahl_ctrl_chk.sv
module ahl_ctrl_chk #(
  parameter int              WIDTH     = 16,
  parameter int              ZERO_N    = 7,
  parameter int              WINDOW    = 1024,
  parameter int              ERR_LIMIT = 3,
  parameter ahl_pkg::bypass_e BYPASS   = ahl_pkg::BYP_COLUMN
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] mcand_i,
  input logic [WIDTH-1:0] mplier_i,
  input logic             timing_err_i,
  input logic             gate_o,
  input logic             aging_o
);
  logic [WIDTH-1:0] seen;
  int               nz;
  int               lim;

  assign seen = (BYPASS == ahl_pkg::BYP_COLUMN) ? mcand_i : mplier_i;
  assign nz   = $countones(~seen);
  assign lim  = aging_o ? ZERO_N + 1 : ZERO_N;

  // R3: a hold never lasts beyond one cycle
  a_r3_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_o |=> gate_o);

  // R2 and R7: enough zeros keeps the gate open
  a_r2_fast_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && nz > lim) |=> gate_o);

  // R3 and R7: too few zeros closes the gate
  a_r3_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && nz <= lim) |=> !gate_o);

  // R6: the aging flag never drops without reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    aging_o |=> aging_o);

  // R5: the aging flag rises only after an error
  a_r5_rise_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aging_o) |-> $past(timing_err_i));
endmodule

bind ahl_ctrl ahl_ctrl_chk #(
  .WIDTH(WIDTH), .ZERO_N(ZERO_N), .WINDOW(WINDOW),
  .ERR_LIMIT(ERR_LIMIT), .BYPASS(BYPASS)
) u_chk (.*);

// File: tb/ahl_ctrl_tb.sv
module ahl_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic         err = 1'b0;
  logic         gate;
  logic         aging;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahl_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mcand_i(mcand), .mplier_i(mplier),
    .timing_err_i(err), .gate_o(gate), .aging_o(aging)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; mcand = '0; mplier = '0; err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // operand expected to pass in one cycle: gate stays high twice
  task automatic expect_pass(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); mcand = a; mplier = b;
    step(); check(req, gate, 1'b1);
    step(); check(req, gate, 1'b1);
    @(negedge clk); mcand = '0; mplier = '0;
  endtask

  // operand expected to need two cycles: exactly one low cycle
  task automatic expect_hold(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); mcand = a; mplier = b;
    step(); check(req, gate, 1'b0);
    step(); check(req, gate, 1'b1);
    @(negedge clk); mcand = '0; mplier = '0;
  endtask

  task automatic pulse_err(input int n);
    @(negedge clk); err = 1'b1;
    repeat (n) @(negedge clk);
    err = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1; check("R1 gate", gate, 1'b1);
    check("R1 aging", aging, 1'b0);
  endtask

  task automatic t_fresh_limits();
    expect_pass("R2 8 zeros", 16'h00FF, '0);
    expect_pass("R2 all zeros", 16'h0000, 16'hFFFF);
    expect_hold("R3 7 zeros", 16'h01FF, '0);
    expect_hold("R3 no zeros", 16'hFFFF, 16'hFFFF);
  endtask

  task automatic t_select();
    expect_hold("R4 mplier ignored (zero)", 16'hFFFF, 16'h0000);
    expect_pass("R4 mplier ignored (ones)", 16'h0000, 16'hFFFF);
  endtask

  task automatic t_window();
    do_reset();
    // three errors in the first window (operations 1..3)
    err = 1'b1;
    repeat (3) @(negedge clk);
    err = 1'b0;
    repeat (1047) @(posedge clk);
    pulse_err(3);
    step(); check("R8 split windows", aging, 1'b0);
    pulse_err(1);
    #1; check("R5 limit exceeded", aging, 1'b1);
  endtask

  task automatic t_aged_limits();
    expect_hold("R7 8 zeros aged", 16'h00FF, '0);
    expect_pass("R7 9 zeros aged", 16'h007F, '0);
  endtask

  task automatic t_sticky();
    pulse_err(2);
    repeat (20) @(posedge clk);
    expect_hold("R6 still aged", 16'h00FF, '0);
    #1; check("R6 aging kept", aging, 1'b1);
    do_reset();
    #1; check("R6 cleared by reset", aging, 1'b0);
  endtask

  initial begin
    t_reset();
    t_fresh_limits();
    t_select();
    t_window();
    t_aged_limits();
    t_sticky();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule